// File: doc/BRIEF.md
# ADC Conversion Window Monitor

This block sits behind an ADC sequencer and inspects every conversion result as it arrives. Each result comes with its channel number, a valid strobe and a resolution code. The block stores the result, left-aligned to 12 bits with the bits below the active resolution forced to zero, in a data register that is visible at its output.

A full-precision guard watches one selected channel against a 12-bit window. It counts consecutive out-of-window results and raises its flag only when that count goes past a programmed filter value. In filtered mode it also lets a DMA request through only for results that lie inside its window. Two reduced-precision guards each watch a set of channels picked by a 19-bit mask. They compare the top 8 bits of the aligned result against 8-bit bounds.

The three flags are sticky until a write-one-to-clear pulse. Each guard's interrupt line is its flag qualified by an enable bit. Every output is registered and changes one clock after the valid strobe.

Top module: `adc_window_guard`

## Requirements
- R1: The stored result equals the input data with low bits zeroed by resolution code: code 0 keeps all 12 bits, code 1 zeroes bits [1:0], code 2 zeroes bits [3:0], code 3 zeroes bits [5:0]. It appears on `rdata` one clock after `resValid`.
- R2: `rdata` is reloaded on every valid conversion, whatever the channel or window outcome. It holds its value when `resValid` is low.
- R3: For the wide guard, an aligned value is out of window when it is strictly above `wd1High` or strictly below `wd1Low`. A value equal to either bound is inside. Only results with `wd1En` high and `resChan == wd1Chan` are evaluated.
- R4: The wide guard counts consecutive out-of-window results on its channel. An inside result resets the count. Flag bit 0 sets on the result that makes the count exceed `wd1Filt`, so a filter of 0 flags on the first one.
- R5: With `wd1FiltMode` high, `dmaReq` pulses one clock after a wide-guard result that is inside the window, and only then. With `wd1FiltMode` low, it pulses after every valid conversion.
- R6: The narrow guards (flag bits 1 and 2) compare bits [11:4] of the aligned value against their 8-bit bounds, using the same strict rule as R3.
- R7: A narrow guard is active only when its mask has at least one bit set. It evaluates a result only if the mask bit indexed by `resChan` is 1. Channels 19 and above are never evaluated.
- R8: Flags are sticky. A 1 in bit i of `flagClr` clears flag i, and clearing bit 0 also resets the filter count. When a set and a clear reach the same flag in one cycle, the set wins.
- R9: `irq[i]` equals `flags[i]` AND `irqEn[i]`.
- R10: After reset, `flags`, `irq`, `dmaReq` and `rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| resValid | input | 1 | Conversion result strobe |
| resData | input | 12 | Raw conversion result, left aligned |
| resChan | input | 5 | Channel of the result |
| resCode | input | 2 | Resolution code (0=12, 1=10, 2=8, 3=6 bits) |
| wd1En | input | 1 | Wide guard enable |
| wd1Chan | input | 5 | Channel watched by the wide guard |
| wd1FiltMode | input | 1 | Gate DMA requests on the wide window |
| wd1High | input | 12 | Wide upper bound |
| wd1Low | input | 12 | Wide lower bound |
| wd1Filt | input | 4 | Out-of-window count to exceed before flagging |
| wd2Mask | input | 19 | Channel mask of narrow guard 2 |
| wd2High | input | 8 | Upper bound of guard 2 |
| wd2Low | input | 8 | Lower bound of guard 2 |
| wd3Mask | input | 19 | Channel mask of narrow guard 3 |
| wd3High | input | 8 | Upper bound of guard 3 |
| wd3Low | input | 8 | Lower bound of guard 3 |
| irqEn | input | 3 | Interrupt enables, bit i for flag i |
| flagClr | input | 3 | Write-one-to-clear pulses for the flags |
| rdata | output | 12 | Last aligned result |
| flags | output | 3 | Sticky guard flags |
| irq | output | 3 | Interrupt lines |
| dmaReq | output | 1 | One-cycle DMA request |

## Verification
The bench puts values exactly on each bound. A design using non-strict compares would then flag or drop DMA on an in-window sample. It drives runs of out-of-window results one shorter than, equal to and one longer than the filter, with inside results in between. An off-by-one count would flag too early or too late, and a count that fails to reset on an inside result would flag across interrupted runs. It uses channels 19 and above with full masks, since a decoder without bounds checking would flag on them. It also makes a set and a clear meet in one cycle, where a clear-first priority would lose the event. Random traffic across all resolution codes catches wrong bit masking, and it would also reveal threshold low bits that are masked instead of being compared.

// File: rtl/adc_guard_pkg.sv
package adc_guard_pkg;
  localparam int DATA_W   = 12;
  localparam int NARROW_W = 8;
  localparam int CHAN_W   = 5;
  localparam int NUM_CH   = 19;
  localparam int FILT_W   = 4;
  localparam int NUM_NARROW = 2;
  localparam int NUM_GUARD  = NUM_NARROW + 1;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
  } ctrlStrobe_t;

  // compare outcomes from datapath to control
  typedef struct packed {
    logic                  wideOut;
    logic [NUM_NARROW-1:0] narrowOut;
  } cmpResult_t;
endpackage

// File: rtl/adc_guard_datapath.sv
module adc_guard_datapath
  import adc_guard_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NW = NARROW_W,
  parameter int NN = NUM_NARROW
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobes,
  input  logic [DW-1:0]         resData,
  input  logic [1:0]            resCode,
  input  logic [DW-1:0]         wideHigh,
  input  logic [DW-1:0]         wideLow,
  input  logic [NN-1:0][NW-1:0] narrowHigh,
  input  logic [NN-1:0][NW-1:0] narrowLow,
  output cmpResult_t            cmp,
  output logic [DW-1:0]         rdata
);
  localparam int SHIFT_W = $clog2(DW) + 1;

  logic [SHIFT_W-1:0] dropBits;
  logic [DW-1:0]      keepMask;
  logic [DW-1:0]      aligned;
  logic [NW-1:0]      topBits;

  // each resolution step drops two more low bits
  assign dropBits = SHIFT_W'({resCode, 1'b0});
  assign keepMask = {DW{1'b1}} << dropBits;
  assign aligned  = resData & keepMask;
  assign topBits  = aligned[DW-1 -: NW];

  // full 12-bit compare; threshold low bits are not masked
  assign cmp.wideOut = (aligned > wideHigh) || (aligned < wideLow);

  for (genvar g = 0; g < NN; g++) begin : gNarrowCmp
    assign cmp.narrowOut[g] = (topBits > narrowHigh[g]) || (topBits < narrowLow[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rdata <= '0;
    else if (strobes.capture) rdata <= aligned;
  end
endmodule

// File: rtl/adc_guard_ctrl.sv
module adc_guard_ctrl
  import adc_guard_pkg::*;
#(
  parameter int CW = CHAN_W,
  parameter int NC = NUM_CH,
  parameter int FW = FILT_W,
  parameter int NN = NUM_NARROW,
  localparam int NG = NN + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  resValid,
  input  logic [CW-1:0]         resChan,
  input  logic                  wideEn,
  input  logic [CW-1:0]         wideChan,
  input  logic                  filtMode,
  input  logic [FW-1:0]         filtLimit,
  input  logic [NN-1:0][NC-1:0] narrowMask,
  input  logic [NG-1:0]         irqEn,
  input  logic [NG-1:0]         flagClr,
  input  cmpResult_t            cmp,
  output ctrlStrobe_t           strobes,
  output logic [NG-1:0]         flags,
  output logic [NG-1:0]         irq,
  output logic                  dmaReq
);
  logic [NC-1:0] chanHot;
  logic          wideHit;
  logic [NN-1:0] narrowHit;
  logic [FW-1:0] runCount;
  logic          wideSet;
  logic [NG-1:0] setVec;

  // one-hot channel decode; channels beyond NC match nothing
  for (genvar c = 0; c < NC; c++) begin : gChanDecode
    assign chanHot[c] = (resChan == CW'(c));
  end

  assign wideHit = resValid && wideEn && (resChan == wideChan);

  for (genvar g = 0; g < NN; g++) begin : gNarrowHit
    assign narrowHit[g] = resValid && (|narrowMask[g]) && (|(narrowMask[g] & chanHot));
  end

  assign strobes.capture = resValid;

  // flag when this out-of-window result pushes the run past the limit
  assign wideSet = wideHit && cmp.wideOut && !flags[0] && (runCount >= filtLimit);

  assign setVec[0] = wideSet;
  for (genvar g = 0; g < NN; g++) begin : gNarrowSet
    assign setVec[g+1] = narrowHit[g] && cmp.narrowOut[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCount <= '0;
    end else if (flagClr[0]) begin
      runCount <= '0;
    end else if (wideHit) begin
      if (!cmp.wideOut)
        runCount <= '0;
      else if (!flags[0] && (runCount < filtLimit))
        runCount <= runCount + 1'b1;
    end
  end

  for (genvar i = 0; i < NG; i++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          flags[i] <= 1'b0;
      else if (setVec[i]) flags[i] <= 1'b1;
      else if (flagClr[i]) flags[i] <= 1'b0;
    end
  end

  assign irq = flags & irqEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         dmaReq <= 1'b0;
    else if (filtMode) dmaReq <= wideHit && !cmp.wideOut;
    else               dmaReq <= resValid;
  end
endmodule

// File: rtl/adc_window_guard.sv
module adc_window_guard
  import adc_guard_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NW = NARROW_W,
  parameter int CW = CHAN_W,
  parameter int NC = NUM_CH,
  parameter int FW = FILT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          resValid,
  input  logic [DW-1:0] resData,
  input  logic [CW-1:0] resChan,
  input  logic [1:0]    resCode,
  input  logic          wd1En,
  input  logic [CW-1:0] wd1Chan,
  input  logic          wd1FiltMode,
  input  logic [DW-1:0] wd1High,
  input  logic [DW-1:0] wd1Low,
  input  logic [FW-1:0] wd1Filt,
  input  logic [NC-1:0] wd2Mask,
  input  logic [NW-1:0] wd2High,
  input  logic [NW-1:0] wd2Low,
  input  logic [NC-1:0] wd3Mask,
  input  logic [NW-1:0] wd3High,
  input  logic [NW-1:0] wd3Low,
  input  logic [2:0]    irqEn,
  input  logic [2:0]    flagClr,
  output logic [DW-1:0] rdata,
  output logic [2:0]    flags,
  output logic [2:0]    irq,
  output logic          dmaReq
);
  ctrlStrobe_t                   strobes;
  cmpResult_t                    cmp;
  logic [NUM_NARROW-1:0][NW-1:0] narrowHigh;
  logic [NUM_NARROW-1:0][NW-1:0] narrowLow;
  logic [NUM_NARROW-1:0][NC-1:0] narrowMask;

  assign narrowHigh = {wd3High, wd2High};
  assign narrowLow  = {wd3Low, wd2Low};
  assign narrowMask = {wd3Mask, wd2Mask};

  adc_guard_datapath #(.DW(DW), .NW(NW), .NN(NUM_NARROW)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .resData(resData), .resCode(resCode),
    .wideHigh(wd1High), .wideLow(wd1Low),
    .narrowHigh(narrowHigh), .narrowLow(narrowLow),
    .cmp(cmp), .rdata(rdata)
  );

  adc_guard_ctrl #(.CW(CW), .NC(NC), .FW(FW), .NN(NUM_NARROW)) ctl (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resChan(resChan),
    .wideEn(wd1En), .wideChan(wd1Chan), .filtMode(wd1FiltMode),
    .filtLimit(wd1Filt), .narrowMask(narrowMask),
    .irqEn(irqEn), .flagClr(flagClr), .cmp(cmp),
    .strobes(strobes), .flags(flags), .irq(irq), .dmaReq(dmaReq)
  );
endmodule

// File: rtl/adc_guard_chk.sv
module adc_guard_chk #(
  parameter int DW = 12,
  parameter int CW = 5,
  parameter int NC = 19
) (
  input logic          clk,
  input logic          rstN,
  input logic          resValid,
  input logic [CW-1:0] resChan,
  input logic          wd1FiltMode,
  input logic [DW-1:0] wd1High,
  input logic [DW-1:0] wd1Low,
  input logic [NC-1:0] wd2Mask,
  input logic [2:0]    flagClr,
  input logic [DW-1:0] rdata,
  input logic [2:0]    flags,
  input logic          dmaReq
);
  // R5
  dma_follows_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> $past(resValid));

  // R5
  dma_in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && $past(wd1FiltMode)) |-> ((rdata <= $past(wd1High)) && (rdata >= $past(wd1Low))));

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |=> $stable(rdata));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((flags & ~flagClr) != 3'b000) |=> ((flags & $past(flags & ~flagClr)) == $past(flags & ~flagClr)));

  // R4
  flag_rise_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((flags & ~$past(flags)) != 3'b000) |-> $past(resValid));

  // R7
  empty_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && (wd2Mask == '0) && !flags[1]) |=> !flags[1]);
endmodule

bind adc_window_guard adc_guard_chk #(.DW(DW), .CW(CW), .NC(NC)) chk (
  .clk(clk), .rstN(rstN), .resValid(resValid), .resChan(resChan),
  .wd1FiltMode(wd1FiltMode), .wd1High(wd1High), .wd1Low(wd1Low),
  .wd2Mask(wd2Mask), .flagClr(flagClr), .rdata(rdata), .flags(flags),
  .dmaReq(dmaReq)
);

// File: tb/adc_window_guard_test.sv
`timescale 1ns/1ps
module adc_window_guard_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resValid = 1'b0;
  logic [11:0] resData = '0;
  logic [4:0]  resChan = '0;
  logic [1:0]  resCode = '0;
  logic        wd1En = 1'b0;
  logic [4:0]  wd1Chan = '0;
  logic        wd1FiltMode = 1'b0;
  logic [11:0] wd1High = '0, wd1Low = '0;
  logic [3:0]  wd1Filt = '0;
  logic [18:0] wd2Mask = '0, wd3Mask = '0;
  logic [7:0]  wd2High = '0, wd2Low = '0, wd3High = '0, wd3Low = '0;
  logic [2:0]  irqEn = '0, flagClr = '0;
  logic [11:0] rdata;
  logic [2:0]  flags, irq;
  logic        dmaReq;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  logic [11:0] mRdata = '0;
  logic [2:0]  mFlags = '0;
  int          mCnt = 0;
  logic        mDma = 1'b0;

  always #4 clk = ~clk;

  adc_window_guard uut (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resData(resData),
    .resChan(resChan), .resCode(resCode), .wd1En(wd1En), .wd1Chan(wd1Chan),
    .wd1FiltMode(wd1FiltMode), .wd1High(wd1High), .wd1Low(wd1Low),
    .wd1Filt(wd1Filt), .wd2Mask(wd2Mask), .wd2High(wd2High), .wd2Low(wd2Low),
    .wd3Mask(wd3Mask), .wd3High(wd3High), .wd3Low(wd3Low),
    .irqEn(irqEn), .flagClr(flagClr), .rdata(rdata), .flags(flags),
    .irq(irq), .dmaReq(dmaReq)
  );

  function automatic logic [11:0] alignRef(logic [11:0] d, logic [1:0] code);
    case (code)
      2'd0: return d;
      2'd1: return {d[11:2], 2'b00};
      2'd2: return {d[11:4], 4'b0000};
      default: return {d[11:6], 6'b000000};
    endcase
  endfunction

  function automatic bit outside(int v, int hi, int lo);
    return (v > hi) || (v < lo);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    check({tag, " R1 R2 rdata"}, 32'(rdata), 32'(mRdata));
    check({tag, " R4 R6 R8 flags"}, 32'(flags), 32'(mFlags));
    check({tag, " R9 irq"}, 32'(irq), 32'(mFlags & irqEn));
    check({tag, " R5 dmaReq"}, 32'(dmaReq), 32'(mDma));
  endtask

  // model update for one conversion, computed from the requirements
  task automatic modelConv(logic [11:0] d, logic [4:0] ch, logic [1:0] code, logic [2:0] clr);
    logic [11:0] a;
    logic [2:0]  sets;
    bit hit1, o1;
    a = alignRef(d, code);
    mRdata = a;
    sets = '0;
    hit1 = wd1En && (ch == wd1Chan);
    o1 = outside(a, wd1High, wd1Low);
    if (hit1 && o1 && !mFlags[0] && (mCnt >= wd1Filt)) sets[0] = 1'b1;
    if (clr[0]) mCnt = 0;
    else if (hit1) begin
      if (!o1) mCnt = 0;
      else if (!mFlags[0] && mCnt < wd1Filt) mCnt++;
    end
    if ((wd2Mask != 0) && ch < 19 && wd2Mask[ch] && outside(a[11:4], wd2High, wd2Low)) sets[1] = 1'b1;
    if ((wd3Mask != 0) && ch < 19 && wd3Mask[ch] && outside(a[11:4], wd3High, wd3Low)) sets[2] = 1'b1;
    mFlags = (mFlags & ~clr) | sets;
    mDma = wd1FiltMode ? (hit1 && !o1) : 1'b1;
  endtask

  task automatic conv(logic [11:0] d, logic [4:0] ch, logic [1:0] code, logic [2:0] clr, string tag);
    @(negedge clk);
    resData = d; resChan = ch; resCode = code; resValid = 1'b1; flagClr = clr;
    modelConv(d, ch, code, clr);
    @(negedge clk);
    resValid = 1'b0; flagClr = '0;
    checkAll(tag);
    mDma = 1'b0;
  endtask

  task automatic clearOnly(logic [2:0] clr, string tag);
    @(negedge clk);
    flagClr = clr;
    mFlags = mFlags & ~clr;
    if (clr[0]) mCnt = 0;
    @(negedge clk);
    flagClr = '0;
    check({tag, " R8 clear"}, 32'(flags), 32'(mFlags));
    check({tag, " R2 rdata kept"}, 32'(rdata), 32'(mRdata));
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired actual=hang expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 flags", 32'(flags), 0);
    check("R10 irq", 32'(irq), 0);
    check("R10 dmaReq", 32'(dmaReq), 0);
    check("R10 rdata", 32'(rdata), 0);
    rstN = 1'b1;

    irqEn = 3'b101;
    wd1En = 1'b1; wd1Chan = 5'd3; wd1FiltMode = 1'b1;
    wd1High = 12'h800; wd1Low = 12'h200; wd1Filt = 4'd0;

    // R1 resolution codes on all-ones data
    for (int c = 0; c < 4; c++) conv(12'hFFF, 5'd9, 2'(c), 3'b000, "R1 code");

    // R3 values on the bounds are inside; R5 DMA passes
    conv(12'h800, 5'd3, 2'd0, 3'b000, "R3 at high");
    conv(12'h200, 5'd3, 2'd0, 3'b000, "R3 at low");
    conv(12'h801, 5'd3, 2'd0, 3'b000, "R3 above high");
    clearOnly(3'b001, "R8 wd1");
    conv(12'h1FF, 5'd4, 2'd0, 3'b000, "R3 other channel");

    // R4 filter of 2: needs three consecutive outs
    wd1Filt = 4'd2;
    conv(12'hF00, 5'd3, 2'd0, 3'b000, "R4 run1");
    conv(12'hF00, 5'd3, 2'd0, 3'b000, "R4 run2");
    conv(12'h400, 5'd3, 2'd0, 3'b000, "R4 reset by inside");
    conv(12'hF00, 5'd3, 2'd0, 3'b000, "R4 run1b");
    conv(12'hF00, 5'd3, 2'd0, 3'b000, "R4 run2b");
    conv(12'hF00, 5'd3, 2'd0, 3'b000, "R4 run3 flags");
    conv(12'h400, 5'd3, 2'd0, 3'b000, "R8 sticky");
    clearOnly(3'b001, "R8 wd1 again");

    // R7 narrow guards: empty mask, high channels, masked channel
    wd2High = 8'h80; wd2Low = 8'h20; wd3High = 8'hC0; wd3Low = 8'h40;
    conv(12'hFF0, 5'd1, 2'd0, 3'b000, "R7 empty masks");
    wd2Mask = '1; wd3Mask = 19'h00004;
    conv(12'hFF0, 5'd19, 2'd0, 3'b000, "R7 chan19");
    conv(12'hFF0, 5'd31, 2'd0, 3'b000, "R7 chan31");
    conv(12'h010, 5'd1, 2'd0, 3'b000, "R7 chan1 masked for wd3");
    // R6 bounds on top byte: 0x80F -> top 0x80 inside
    conv(12'h80F, 5'd2, 2'd0, 3'b000, "R6 top at high");
    conv(12'h810, 5'd2, 2'd0, 3'b000, "R6 top above high");
    // R8 set beats clear
    conv(12'h810, 5'd2, 2'd0, 3'b010, "R8 set wins");
    clearOnly(3'b111, "R8 all");

    // R5 unfiltered DMA on every conversion
    wd1FiltMode = 1'b0;
    conv(12'hFFF, 5'd3, 2'd0, 3'b000, "R5 unfiltered out");
    conv(12'h123, 5'd7, 2'd1, 3'b000, "R5 unfiltered other");
    clearOnly(3'b111, "R8 reset flags");

    // random traffic
    for (int k = 0; k < 400; k++) begin
      if (k % 50 == 0) begin
        wd1FiltMode = 1'($urandom);
        wd1Chan = 5'($urandom_range(0, 5));
        wd1Filt = 4'($urandom_range(0, 4));
        wd1Low = 12'($urandom_range(0, 1800));
        wd1High = wd1Low + 12'($urandom_range(0, 2000));
        wd2Low = 8'($urandom_range(0, 100));
        wd2High = wd2Low + 8'($urandom_range(0, 120));
        wd3Low = 8'($urandom_range(0, 100));
        wd3High = wd3Low + 8'($urandom_range(0, 120));
        wd2Mask = 19'($urandom);
        wd3Mask = ($urandom_range(0, 3) == 0) ? 19'h0 : 19'($urandom);
        irqEn = 3'($urandom);
      end
      if ($urandom_range(0, 9) == 0)
        clearOnly(3'($urandom), "rand");
      else
        conv(12'($urandom), 5'($urandom_range(0, 23)), 2'($urandom),
             ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b000, "rand");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule